// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O

This block is a general-purpose parallel I/O peripheral. It presents three 8-bit ports, named A, B and C, to the outside world. On the CPU side it has an 8-bit data bus, an active-low select, active-low read and write strobes, and a two-bit address. Port C is split into two 4-bit halves that take their direction independently. The ports form two groups. One group is port A with the upper half of C. The other is port B with the lower half of C.

A control word written by the CPU sets the direction of each of the four port sections. A second form of control word sets or clears one bit of port C. The port pins are modelled as separate input, output and output-enable vectors, so the block can sit behind a pad ring or a tri-state wrapper. Only the plain latched-output, unlatched-input mode is built. Any handshake mode selected in the control word has no effect. Writes are taken on the rising clock edge while the strobes are low. Reads are combinational.

Top module: `ppio_top`

## Requirements
- R1: With `cs_n` low, address 0 targets port A, 1 targets port B, 2 targets port C and 3 targets the control word. With `cs_n` high, a low `wr_n` changes no latch and no direction.
- R2: `dout_oe` is 1 exactly while `cs_n` and `rd_n` are both low, in the same cycle. While it is 0, `dout` is all zeros.
- R3: A write to port A, B or C loads the bus value into that port's latch at the rising edge. The latch appears on `pa_out`, `pb_out` or `pc_out` from that edge on, whatever the direction.
- R4: While `rst` is high, and right after it falls, every output enable is 0 (all ports input) and every latch is 0.
- R5: A control write with bit 7 = 1 is a mode word. Bit 4 = 1 makes port A input, bit 3 = 1 makes C[7:4] input, bit 1 = 1 makes port B input and bit 0 = 1 makes C[3:0] input. A 0 in any of these bits makes that section output. The enables (`pa_oe`, `pb_oe`, `pc_oe` per bit) follow from the next edge.
- R6: A mode word clears the latches of ports A, B and C to zero.
- R7: A control write with bit 7 = 0 sets C latch bit number `din[3:1]` to `din[0]`. All other C bits and all directions stay unchanged.
- R8: Reading a port section configured as input returns the live pin value in the same cycle, with no latching.
- R9: Reading a port section configured as output returns its latch. Port C is resolved per 4-bit half.
- R10: Mode word bits 6, 5 and 2, which choose the handshake modes, are ignored. The directions depend only on bits 4, 3, 1 and 0.
- R11: A read at address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Target: 0 port A, 1 port B, 2 port C, 3 control |
| din | input | 8 | CPU write data |
| dout | output | 8 | CPU read data |
| dout_oe | output | 1 | Enable for the CPU data bus driver |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A drive enable per bit |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B drive enable per bit |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C drive enable per bit |

## Verification
Reads have no register on their path, so `dout` and `dout_oe` are due in the same cycle as the strobe. The bench drives a read at the falling edge and samples 1 ns later, before any rising edge. Writes, mode words and bit set/reset pass through one register stage. The bench holds the strobes across one rising edge, releases them at the next falling edge, and checks the port outputs and enables at that point. It also changes pin inputs between reads to show that input reads are not latched.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } ppio_sel_e;

    // direction flags, 1 = section drives its pins
    typedef struct packed {
        logic a_out;
        logic cu_out;
        logic b_out;
        logic cl_out;
    } ppio_dir_t;

    // control word bit positions for input selection
    localparam int CW_A_IN  = 4;
    localparam int CW_CU_IN = 3;
    localparam int CW_B_IN  = 1;
    localparam int CW_CL_IN = 0;

endpackage

// File: rtl/ppio_decode.sv
module ppio_decode
    import ppio_pkg::*;
(
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    output logic       wr_a,
    output logic       wr_b,
    output logic       wr_c,
    output logic       wr_ctrl,
    output logic       rd_en,
    output ppio_sel_e  rd_sel
);

    logic      wr_any;
    ppio_sel_e sel;

    always_comb begin
        sel     = ppio_sel_e'(addr);
        wr_any  = !cs_n && !wr_n;
        rd_en   = !cs_n && !rd_n;
        rd_sel  = sel;
        wr_a    = wr_any && (sel == SEL_A);
        wr_b    = wr_any && (sel == SEL_B);
        wr_c    = wr_any && (sel == SEL_C);
        wr_ctrl = wr_any && (sel == SEL_CTRL);
    end

endmodule

// File: rtl/ppio_regs.sv
module ppio_regs
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic          wr_c,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] lat_a,
    output logic [DW-1:0] lat_b,
    output logic [DW-1:0] lat_c,
    output ppio_dir_t     dir
);

    localparam int SELW    = $clog2(DW);
    localparam int MODE_BIT = DW - 1;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] c;
        ppio_dir_t     dir;
    } state_t;

    state_t st_d, st_q;
    logic   unused_hs_bits;

    assign unused_hs_bits = ^{din[6:5], din[2]};

    always_comb begin
        st_d = st_q;
        if (wr_a) st_d.a = din;
        if (wr_b) st_d.b = din;
        if (wr_c) st_d.c = din;
        if (wr_ctrl) begin
            if (din[MODE_BIT]) begin
                st_d.dir.a_out  = !din[CW_A_IN];
                st_d.dir.cu_out = !din[CW_CU_IN];
                st_d.dir.b_out  = !din[CW_B_IN];
                st_d.dir.cl_out = !din[CW_CL_IN];
                st_d.a = '0;
                st_d.b = '0;
                st_d.c = '0;
            end else begin
                st_d.c[din[SELW:1]] = din[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lat_a = st_q.a;
    assign lat_b = st_q.b;
    assign lat_c = st_q.c;
    assign dir   = st_q.dir;

    // R3
    porta_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_a |=> st_q.a == $past(din));

    // R6
    mode_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && din[MODE_BIT]) |=> (st_q.a == '0 && st_q.b == '0 && st_q.c == '0));

    // R7
    bitset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !din[MODE_BIT]) |=>
            (st_q.c[$past(din[SELW:1])] == $past(din[0]) && $stable(st_q.dir)));

    // R4
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> st_q == '0);

endmodule

// File: rtl/ppio_rdmux.sv
module ppio_rdmux
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          rd_en,
    input  ppio_sel_e     rd_sel,
    input  ppio_dir_t     dir,
    input  logic [DW-1:0] lat_a,
    input  logic [DW-1:0] lat_b,
    input  logic [DW-1:0] lat_c,
    input  logic [DW-1:0] pin_a,
    input  logic [DW-1:0] pin_b,
    input  logic [DW-1:0] pin_c,
    output logic [DW-1:0] dout
);

    localparam int HALF = DW / 2;

    logic [DW-1:0] view_a, view_b, view_c;

    assign view_a = dir.a_out ? lat_a : pin_a;
    assign view_b = dir.b_out ? lat_b : pin_b;

    for (genvar h = 0; h < 2; h++) begin : g_chalf
        logic half_out;
        assign half_out = (h == 1) ? dir.cu_out : dir.cl_out;
        assign view_c[h*HALF +: HALF] = half_out ? lat_c[h*HALF +: HALF]
                                                 : pin_c[h*HALF +: HALF];
    end

    always_comb begin
        dout = '0;
        if (rd_en) begin
            unique case (rd_sel)
                SEL_A:    dout = view_a;
                SEL_B:    dout = view_b;
                SEL_C:    dout = view_c;
                SEL_CTRL: dout = '0;
            endcase
        end
    end

endmodule

// File: rtl/ppio_top.sv
module ppio_top
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);

    localparam int HALF = DW / 2;

    logic      wr_a, wr_b, wr_c, wr_ctrl, rd_en;
    ppio_sel_e rd_sel;
    ppio_dir_t dir;

    ppio_decode u_decode (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .wr_c    (wr_c),
        .wr_ctrl (wr_ctrl),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel)
    );

    ppio_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .wr_c    (wr_c),
        .wr_ctrl (wr_ctrl),
        .din     (din),
        .lat_a   (pa_out),
        .lat_b   (pb_out),
        .lat_c   (pc_out),
        .dir     (dir)
    );

    ppio_rdmux #(.DW(DW)) u_rdmux (
        .rd_en  (rd_en),
        .rd_sel (rd_sel),
        .dir    (dir),
        .lat_a  (pa_out),
        .lat_b  (pb_out),
        .lat_c  (pc_out),
        .pin_a  (pa_in),
        .pin_b  (pb_in),
        .pin_c  (pc_in),
        .dout   (dout)
    );

    assign dout_oe = rd_en;
    assign pa_oe   = {DW{dir.a_out}};
    assign pb_oe   = {DW{dir.b_out}};

    for (genvar h = 0; h < 2; h++) begin : g_coe
        assign pc_oe[h*HALF +: HALF] = {HALF{(h == 1) ? dir.cu_out : dir.cl_out}};
    end

    // R1
    deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                  $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    // R2
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> dout == '0);

    // R5
    half_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(pc_oe[HALF-1:0]) == 0 || $countones(pc_oe[HALF-1:0]) == HALF));

endmodule

// File: tb/ppio_top_bench.sv
module ppio_top_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, rd_n, wr_n;
    logic [1:0] addr;
    logic [7:0] din, dout;
    logic       dout_oe;
    logic [7:0] pa_in, pa_out, pa_oe;
    logic [7:0] pb_in, pb_out, pb_oe;
    logic [7:0] pc_in, pc_out, pc_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [7:0] m_a, m_b, m_c;
    logic       d_a, d_b, d_cu, d_cl;

    always #4 clk = ~clk;

    ppio_top u_ppio_top (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return d_a ? m_a : pa_in;
            2'd1:    return d_b ? m_b : pb_in;
            2'd2:    return {d_cu ? m_c[7:4] : pc_in[7:4], d_cl ? m_c[3:0] : pc_in[3:0]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: m_a = d;
            2'd1: m_b = d;
            2'd2: m_c = d;
            default: begin
                if (d[7]) begin
                    d_a = !d[4]; d_cu = !d[3]; d_b = !d[1]; d_cl = !d[0];
                    m_a = '0; m_b = '0; m_c = '0;
                end else begin
                    m_c[d[3:1]] = d[0];
                end
            end
        endcase
    endfunction

    task automatic check_pins(input string tag);
        chk({tag, " R3 pa_out"}, pa_out, m_a);
        chk({tag, " R3 pb_out"}, pb_out, m_b);
        chk({tag, " R3 pc_out"}, pc_out, m_c);
        chk({tag, " R5 pa_oe"}, pa_oe, {8{d_a}});
        chk({tag, " R5 pb_oe"}, pb_oe, {8{d_b}});
        chk({tag, " R5 pc_oe"}, pc_oe, {{4{d_cu}}, {4{d_cl}}});
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(a, d);
        #1;
    endtask

    task automatic do_read(input string tag, input logic [1:0] a);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        chk({tag, " R2 dout_oe"}, dout_oe, 1'b1);
        chk(tag, dout, exp_read(a));
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        addr = '0; din = '0;
        pa_in = 8'h3C; pb_in = 8'hC3; pc_in = 8'h96;
        m_a = '0; m_b = '0; m_c = '0;
        d_a = 0; d_b = 0; d_cu = 0; d_cl = 0;
        repeat (4) @(negedge clk);
        #1;
        check_pins("R4 during reset");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check_pins("R4 after reset");

        // R8: reads after reset follow pins
        do_read("R8 read A input", 2'd0);
        // R2: read strobe without select
        @(negedge clk);
        rd_n = 1'b0; cs_n = 1'b1; addr = 2'd0;
        #1;
        chk("R2 oe needs select", dout_oe, 1'b0);
        chk("R2 dout zero idle", dout, 8'h00);
        rd_n = 1'b1;

        // R5: all output
        do_write(2'd3, 8'h80);
        check_pins("R5 all out");
        do_write(2'd0, 8'h5A);
        check_pins("R3 write A");
        do_read("R9 read A latch", 2'd0);

        // R1: write with select high is dropped
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hFF;
        @(negedge clk);
        wr_n = 1'b1;
        #1;
        chk("R1 deselected write", pa_out, 8'h5A);

        // R6/R5: all input with handshake bits set
        do_write(2'd3, 8'hFF);
        check_pins("R6 R10 all in");
        chk("R6 latch cleared", pa_out, 8'h00);
        do_read("R8 read A pins", 2'd0);
        @(negedge clk);
        pa_in = 8'hE7;
        do_read("R8 pins not latched", 2'd0);

        // R10: handshake bits ignored
        do_write(2'd3, 8'hE4);
        check_pins("R10 hs bits");
        chk("R10 pa_oe", pa_oe, 8'hFF);
        chk("R10 pb_oe", pb_oe, 8'hFF);

        // R9 mixed port C
        do_write(2'd3, 8'h88);
        do_write(2'd2, 8'hA5);
        check_pins("R9 mixed C");
        do_read("R9 read C mixed", 2'd2);

        // R7 bit set/reset
        do_write(2'd3, 8'h0F);
        check_pins("R7 set bit7");
        chk("R7 bit7 set", pc_out, 8'h25 | 8'h80);
        do_write(2'd3, 8'h04);
        check_pins("R7 clear bit2");
        chk("R7 bit2 clear", pc_out, 8'hA1);

        // R11 control read
        do_read("R11 read ctrl", 2'd3);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 5);
            @(negedge clk);
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            case (op)
                0: do_write(2'($urandom_range(0, 2)), 8'($urandom));
                1: do_write(2'd3, 8'($urandom) | 8'h80);
                2: do_write(2'd3, 8'($urandom) & 8'h0F);
                3: do_read("R8 R9 rand read", 2'($urandom));
                4: begin
                    @(negedge clk);
                    cs_n = 1'b1; wr_n = 1'b0; addr = 2'($urandom); din = 8'($urandom);
                    @(negedge clk);
                    wr_n = 1'b1;
                    #1;
                end
                default: do_read("R8 R9 rand read", 2'($urandom_range(0, 2)));
            endcase
            check_pins("R1 R3 R5 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule